// File: doc/BRIEF.md
# Dual-Mode Infrared Interrupt Status Unit

This block gathers the event pulses of an infrared serial controller into two independent banks of sticky status bits. One bank serves the slow asynchronous (SIR) datapath and the other serves the faster MIR/FIR datapath. Both banks use the same bit layout. Bits 9 and 8 mean different things in each bank: in the SIR bank they flag a receive timeout and a framing error, and in the MIR/FIR bank they flag an abort and a CRC error.

Firmware uses a small 16-bit register port to read status, program per-bit masks, and clear events by writing ones. The usual flow is to read a status register and write the same value back to that bank's clear register. A transfer-mode register holds the 2-bit mode field and three top-level mask bits: one for each bank and one for the FIFO receive request. Together these gate a single registered interrupt line.

Top module: `ir_irq_unit`

## Requirements
- R1: After a synchronous reset, the following hold. The mode register reads 0x0111, so the mode field is 00 and all three top-level mask bits are set. Both bank mask registers read 0x8B80. Both status registers read 0. `irq_o` is 0 and `rdata` is 0.
- R2: An event pulse sets its status bit in the clock edge that samples it, and the bit stays set until cleared. The index of each event input maps to a status bit as follows: 0→bit 7 (frame transmitted), 1→bit 8 (SIR framing error / MIR-FIR CRC error), 2→bit 9 (SIR timeout / MIR-FIR abort), 3→bit 11 (transfer-area overflow), 4→bit 15 (frame received).
- R3: Writing a bank's clear register clears exactly the status bits written as 1 and leaves all other bits unchanged. Writing back a value just read from status therefore clears exactly those bits.
- R4: If an event pulse and a clear write hit the same bit in the same cycle, the bit ends set.
- R5: Unimplemented bits read 0. Clear registers and address 7 read 0. Writes to the status addresses are ignored.
- R6: `irq_o` is a register. After each edge it holds the OR of three terms taken from the state before that edge: (SIR status AND NOT SIR mask) unless mode bit 0 is set, (MIR/FIR status AND NOT MIR/FIR mask) unless mode bit 4 is set, and `fifo_rx_req` unless mode bit 8 is set.
- R7: Mode bits 15:14 store the transfer mode (00 SIR, 10 FIR, 11 MIR) and drive `mode_o`.
- R8: The register map is: 0 mode, 1/2/3 SIR status/mask/clear, 4/5/6 MIR-FIR status/mask/clear. `rdata` is loaded one edge after a cycle with `rd_en` high and holds its value otherwise.
- R9: A set bank-mask bit blocks that bit's interrupt contribution but does not stop the status bit from being set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 3 | Register address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Registered read data |
| sir_evt | input | 5 | SIR event pulses |
| mf_evt | input | 5 | MIR/FIR event pulses |
| fifo_rx_req | input | 1 | FIFO receive request level |
| mode_o | output | 2 | Transfer mode field |
| irq_o | output | 1 | Registered interrupt |

## Verification
A corrupted status or mask bit shows up at `irq_o` at the next edge once the relevant top-level mask is open. It shows up in `rdata` one edge after any read of that bank. A lost event, a clear that hits the wrong bits, or a clear that wins over a simultaneous event therefore appears within two cycles of the next read. The bench keeps a behavioural model alongside the design and compares `irq_o`, `rdata` and `mode_o` on every cycle, so such a divergence is flagged at the cycle where it first becomes visible at the ports.

// File: rtl/ir_irq_pkg.sv
package ir_irq_pkg;
  localparam int DATA_W = 16;
  localparam int ADDR_W = 3;
  localparam int N_EVT  = 5;
  localparam int N_BANK = 2;

  // status bit position of each event index (tx end, bit8 err, bit9 err, overflow, rx end)
  localparam int EVT_POS [N_EVT] = '{7, 8, 9, 11, 15};

  localparam int MODE_LSB      = 14;
  localparam int MSK_SIR_BIT   = 0;
  localparam int MSK_MF_BIT    = 4;
  localparam int MSK_FIFO_BIT  = 8;

  localparam logic [DATA_W-1:0] MODE_IMPL =
    (DATA_W'(3) << MODE_LSB) | (DATA_W'(1) << MSK_SIR_BIT) |
    (DATA_W'(1) << MSK_MF_BIT) | (DATA_W'(1) << MSK_FIFO_BIT);
  localparam logic [DATA_W-1:0] MODE_RST =
    (DATA_W'(1) << MSK_SIR_BIT) | (DATA_W'(1) << MSK_MF_BIT) |
    (DATA_W'(1) << MSK_FIFO_BIT);

  typedef enum logic [ADDR_W-1:0] {
    A_MODE     = 3'd0,
    A_SIR_STAT = 3'd1,
    A_SIR_MASK = 3'd2,
    A_SIR_CLR  = 3'd3,
    A_MF_STAT  = 3'd4,
    A_MF_MASK  = 3'd5,
    A_MF_CLR   = 3'd6,
    A_SPARE    = 3'd7
  } reg_addr_e;

  typedef enum logic [1:0] {K_STAT = 2'd0, K_MASK = 2'd1, K_CLR = 2'd2} reg_kind_e;

  function automatic logic [DATA_W-1:0] evt_spread(input logic [N_EVT-1:0] e);
    logic [DATA_W-1:0] v;
    v = '0;
    for (int k = 0; k < N_EVT; k++) v[EVT_POS[k]] = e[k];
    return v;
  endfunction

  function automatic logic [ADDR_W-1:0] bank_addr(input int bank, input reg_kind_e kind);
    return ADDR_W'(1 + 3 * bank + int'(kind));
  endfunction
endpackage

// File: rtl/ir_evt_bank.sv
module ir_evt_bank
  import ir_irq_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int NE = N_EVT
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [NE-1:0] evt,
  input  logic          clr_we,
  input  logic          msk_we,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] status,
  output logic [DW-1:0] mask,
  output logic          pending
);
  localparam logic [DW-1:0] IMPL = DW'(evt_spread('1));

  logic [DW-1:0] set_v;
  logic [DW-1:0] clr_v;
  logic [DW-1:0] stat_n;

  always_comb begin
    set_v  = DW'(evt_spread(N_EVT'(evt)));
    clr_v  = clr_we ? wdata : '0;
    // a new event takes priority over a clear of the same bit
    stat_n = ((status & ~clr_v) | set_v) & IMPL;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      status <= '0;
      mask   <= IMPL;
    end else begin
      status <= stat_n;
      if (msk_we) mask <= wdata & IMPL;
    end
  end

  assign pending = |(status & ~mask);
endmodule

// File: rtl/ir_mode_reg.sv
module ir_mode_reg
  import ir_irq_pkg::*;
#(
  parameter int DW = DATA_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] value,
  output logic [1:0]    mode,
  output logic          sir_off,
  output logic          mf_off,
  output logic          fifo_off
);
  always_ff @(posedge clk) begin
    if (rst)     value <= DW'(MODE_RST);
    else if (we) value <= wdata & DW'(MODE_IMPL);
  end

  assign mode     = value[MODE_LSB +: 2];
  assign sir_off  = value[MSK_SIR_BIT];
  assign mf_off   = value[MSK_MF_BIT];
  assign fifo_off = value[MSK_FIFO_BIT];
endmodule

// File: rtl/ir_reg_port.sv
module ir_reg_port
  import ir_irq_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int AW = ADDR_W,
  parameter int NB = N_BANK
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   wr_en,
  input  logic                   rd_en,
  input  logic [AW-1:0]          addr,
  input  logic [DW-1:0]          mode_val,
  input  logic [NB-1:0][DW-1:0]  stat,
  input  logic [NB-1:0][DW-1:0]  mask,
  output logic                   mode_we,
  output logic [NB-1:0]          clr_we,
  output logic [NB-1:0]          msk_we,
  output logic [DW-1:0]          rdata
);
  logic [DW-1:0] rd_mux;

  assign mode_we = wr_en && (addr == AW'(A_MODE));

  for (genvar b = 0; b < NB; b++) begin : g_dec
    assign clr_we[b] = wr_en && (addr == AW'(bank_addr(b, K_CLR)));
    assign msk_we[b] = wr_en && (addr == AW'(bank_addr(b, K_MASK)));
  end

  always_comb begin
    rd_mux = '0;
    if (addr == AW'(A_MODE)) rd_mux = mode_val;
    for (int b = 0; b < NB; b++) begin
      if (addr == AW'(bank_addr(b, K_STAT))) rd_mux = stat[b];
      if (addr == AW'(bank_addr(b, K_MASK))) rd_mux = mask[b];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_en) rdata <= rd_mux;
  end
endmodule

// File: rtl/ir_irq_unit.sv
module ir_irq_unit
  import ir_irq_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int AW = ADDR_W,
  parameter int NE = N_EVT
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  input  logic [NE-1:0] sir_evt,
  input  logic [NE-1:0] mf_evt,
  input  logic          fifo_rx_req,
  output logic [1:0]    mode_o,
  output logic          irq_o
);
  localparam int NB = N_BANK;

  logic [NB-1:0][NE-1:0] evt_all;
  logic [NB-1:0][DW-1:0] bank_stat;
  logic [NB-1:0][DW-1:0] bank_mask;
  logic [NB-1:0]         bank_pend;
  logic [NB-1:0]         bank_off;
  logic [NB-1:0]         clr_we;
  logic [NB-1:0]         msk_we;
  logic [DW-1:0]         mode_val;
  logic                  mode_we;
  logic                  sir_off;
  logic                  mf_off;
  logic                  fifo_off;

  assign evt_all  = {mf_evt, sir_evt};
  assign bank_off = {mf_off, sir_off};

  ir_reg_port #(.DW(DW), .AW(AW), .NB(NB)) u_port (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .mode_val(mode_val), .stat(bank_stat), .mask(bank_mask),
    .mode_we(mode_we), .clr_we(clr_we), .msk_we(msk_we), .rdata(rdata)
  );

  ir_mode_reg #(.DW(DW)) u_mode (
    .clk(clk), .rst(rst), .we(mode_we), .wdata(wdata), .value(mode_val),
    .mode(mode_o), .sir_off(sir_off), .mf_off(mf_off), .fifo_off(fifo_off)
  );

  for (genvar b = 0; b < NB; b++) begin : g_bank
    ir_evt_bank #(.DW(DW), .NE(NE)) u_bank (
      .clk(clk), .rst(rst), .evt(evt_all[b]), .clr_we(clr_we[b]),
      .msk_we(msk_we[b]), .wdata(wdata), .status(bank_stat[b]),
      .mask(bank_mask[b]), .pending(bank_pend[b])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) irq_o <= 1'b0;
    else     irq_o <= (|(bank_pend & ~bank_off)) | (fifo_rx_req & ~fifo_off);
  end
endmodule

// File: rtl/ir_irq_chk.sv
module ir_irq_chk
  import ir_irq_pkg::*;
(
  input logic                        clk,
  input logic                        rst,
  input logic                        wr_en,
  input logic                        rd_en,
  input logic [ADDR_W-1:0]           addr,
  input logic [DATA_W-1:0]           wdata,
  input logic [N_EVT-1:0]            sir_evt,
  input logic [N_EVT-1:0]            mf_evt,
  input logic [DATA_W-1:0]           rdata,
  input logic                        irq_o,
  input logic [DATA_W-1:0]           mode_val,
  input logic [N_BANK-1:0][DATA_W-1:0] bank_stat
);
  logic sir_clr, mf_clr;
  assign sir_clr = wr_en && (addr == ADDR_W'(A_SIR_CLR));
  assign mf_clr  = wr_en && (addr == ADDR_W'(A_MF_CLR));

  p_reset_quiet_r1: assert property (@(posedge clk) rst |=> (!irq_o && rdata == '0));

  p_evt_sets_r2: assert property (@(posedge clk) disable iff (rst)
    sir_evt[0] |=> bank_stat[0][7]);

  p_sticky_r2: assert property (@(posedge clk) disable iff (rst)
    !sir_clr |=> ((bank_stat[0] & $past(bank_stat[0])) == $past(bank_stat[0])));

  p_evt_wins_r4: assert property (@(posedge clk) disable iff (rst)
    (mf_evt[4] && mf_clr && wdata[15]) |=> bank_stat[1][15]);

  p_all_masked_r6: assert property (@(posedge clk) disable iff (rst)
    (mode_val[MSK_SIR_BIT] && mode_val[MSK_MF_BIT] && mode_val[MSK_FIFO_BIT]) |=> !irq_o);

  p_rdata_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rdata));
endmodule

bind ir_irq_unit ir_irq_chk u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
  .wdata(wdata), .sir_evt(sir_evt), .mf_evt(mf_evt), .rdata(rdata),
  .irq_o(irq_o), .mode_val(mode_val), .bank_stat(bank_stat)
);

// File: tb/tb_ir_irq_unit.sv
module tb_ir_irq_unit;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [2:0] addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic [4:0] sir_evt = '0, mf_evt = '0;
  logic fifo_rx_req = 1'b0;
  logic [1:0] mode_o;
  logic irq_o;

  int checks = 0, failures = 0, cyc = 0;
  bit done = 0;

  always #5 clk = ~clk;

  ir_irq_unit dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .sir_evt(sir_evt), .mf_evt(mf_evt),
    .fifo_rx_req(fifo_rx_req), .mode_o(mode_o), .irq_o(irq_o)
  );

  // behavioural reference model
  int pos_of [5] = '{7, 8, 9, 11, 15};
  logic [15:0] m_stat [2];
  logic [15:0] m_mask [2];
  logic [15:0] m_mode;
  logic [15:0] m_rdata;
  logic        m_irq;

  function automatic logic [15:0] m_read(input int a);
    case (a)
      0: return m_mode;
      1: return m_stat[0];
      2: return m_mask[0];
      4: return m_stat[1];
      5: return m_mask[1];
      default: return 16'h0000;
    endcase
  endfunction

  always @(posedge clk) begin
    logic [15:0] ns [2];
    logic [4:0] ev [2];
    if (rst) begin
      m_stat[0] <= 0; m_stat[1] <= 0;
      m_mask[0] <= 16'h8B80; m_mask[1] <= 16'h8B80;
      m_mode <= 16'h0111; m_rdata <= 0; m_irq <= 0;
    end else begin
      logic p;
      p = 0;
      if (!m_mode[0] && (m_stat[0] & ~m_mask[0]) != 0) p = 1;
      if (!m_mode[4] && (m_stat[1] & ~m_mask[1]) != 0) p = 1;
      if (!m_mode[8] && fifo_rx_req) p = 1;
      m_irq <= p;
      if (rd_en) m_rdata <= m_read(int'(addr));
      ev[0] = sir_evt; ev[1] = mf_evt;
      for (int b = 0; b < 2; b++) begin
        ns[b] = m_stat[b];
        if (wr_en && int'(addr) == 3 + 3 * b) ns[b] = ns[b] & ~wdata;
        for (int k = 0; k < 5; k++) if (ev[b][k]) ns[b][pos_of[k]] = 1'b1;
        m_stat[b] <= ns[b];
        if (wr_en && int'(addr) == 2 + 3 * b) m_mask[b] <= wdata & 16'h8B80;
      end
      if (wr_en && addr == 3'd0) m_mode <= wdata & 16'hC111;
    end
  end

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // compare model against design every cycle, away from the active edge
  always @(negedge clk) begin
    if (!rst && !done) begin
      chk("R6 irq_o vs model", {15'd0, irq_o}, {15'd0, m_irq});
      chk("R8 rdata vs model", rdata, m_rdata);
      chk("R7 mode_o vs model", {14'd0, mode_o}, {14'd0, m_mode[15:14]});
    end
  end

  task automatic wr(input int a, input logic [15:0] d, input logic [4:0] se = 0, input logic [4:0] me = 0);
    @(negedge clk);
    wr_en = 1; addr = 3'(a); wdata = d; sir_evt = se; mf_evt = me;
    @(negedge clk);
    wr_en = 0; sir_evt = 0; mf_evt = 0;
  endtask

  task automatic pulse(input logic [4:0] se, input logic [4:0] me);
    @(negedge clk);
    sir_evt = se; mf_evt = me;
    @(negedge clk);
    sir_evt = 0; mf_evt = 0;
  endtask

  task automatic rd(input int a, input logic [15:0] exp, input string tag);
    @(negedge clk);
    rd_en = 1; addr = 3'(a);
    @(negedge clk);
    rd_en = 0;
    #1 chk(tag, rdata, exp);
  endtask

  task automatic irq_is(input logic exp, input string tag);
    repeat (2) @(negedge clk);
    #1 chk(tag, {15'd0, irq_o}, {15'd0, exp});
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000 && !done) begin
      done = 1;
      failures++;
      $display("FAIL watchdog actual=%0d expected<50000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    repeat (3) @(negedge clk);
    rst = 0;
    #1;
    chk("R1 irq after reset", {15'd0, irq_o}, 16'd0);
    chk("R1 rdata after reset", rdata, 16'd0);
    rd(0, 16'h0111, "R1 mode reset");
    rd(2, 16'h8B80, "R1 SIR mask reset");
    rd(5, 16'h8B80, "R1 MF mask reset");
    rd(1, 16'h0000, "R1 SIR status reset");
    rd(4, 16'h0000, "R1 MF status reset");

    // R2: each event index to its bit
    pulse(5'b00001, 0); rd(1, 16'h0080, "R2 idx0 bit7");
    pulse(5'b01000, 0); rd(1, 16'h0880, "R2 idx3 bit11 sticky");
    pulse(5'b10110, 0); rd(1, 16'h8B80, "R2 all SIR bits");
    pulse(0, 5'b00010); rd(4, 16'h0100, "R2 MF CRC bit8");
    irq_is(0, "R6 all masked");

    // R6: bank mask open but top-level SIR mask set
    wr(2, 16'h0000); irq_is(0, "R6 top SIR mask blocks");
    wr(0, 16'h0110); irq_is(1, "R6 SIR enabled");

    // R3: clear by ones, then read-back write-back
    wr(3, 16'h0080); rd(1, 16'h8B00, "R3 clear bit7 only");
    rd(1, 16'h8B00, "R3 readback");
    v = rdata;
    wr(3, v); rd(1, 16'h0000, "R3 writeback clears all");
    irq_is(0, "R6 irq drops after clear");

    // R4: event wins over simultaneous clear
    wr(3, 16'h8000, 5'b10000, 0); rd(1, 16'h8000, "R4 event beats clear");
    wr(6, 16'h8100, 0, 5'b10000); rd(4, 16'h8000, "R4 MF event beats clear, bit8 cleared");

    // R5: unimplemented bits, clear and spare reads, status write ignored
    wr(2, 16'hFFFF); rd(2, 16'h8B80, "R5 mask unimpl bits");
    rd(3, 16'h0000, "R5 clear reads 0");
    rd(7, 16'h0000, "R5 spare reads 0");
    wr(1, 16'h0000); rd(1, 16'h8000, "R5 status write ignored");

    // R7: mode field encodings
    wr(0, 16'h8111); #1 chk("R7 FIR mode_o", {14'd0, mode_o}, 16'd2);
    wr(0, 16'hC111); #1 chk("R7 MIR mode_o", {14'd0, mode_o}, 16'd3);
    wr(0, 16'hFFFF); rd(0, 16'hC111, "R7 R5 mode unimpl bits");

    // R6: FIFO request gating
    wr(0, 16'h0011); fifo_rx_req = 1; irq_is(1, "R6 fifo request");
    wr(0, 16'h0111); irq_is(0, "R6 fifo masked");
    fifo_rx_req = 0;

    // R9: MF bank mask blocks irq but status still sets
    wr(2, 16'h8B80); wr(3, 16'hFFFF);
    wr(5, 16'h0100); wr(0, 16'h0101);
    pulse(0, 5'b00010); rd(4, 16'h8100, "R9 masked bit still sets");
    wr(6, 16'h8000); irq_is(0, "R9 masked bit no irq");
    wr(5, 16'h0000); irq_is(1, "R9 unmasked bit irq");

    // R8: rdata holds without read
    rd(5, 16'h0000, "R8 read MF mask");
    pulse(5'b11111, 5'b11111);
    repeat (3) @(negedge clk);
    #1 chk("R8 rdata holds", rdata, 16'h0000);
    rd(4, 16'h8B80, "R8 R2 MF all bits");

    repeat (3) @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule